// File: doc/BRIEF.md
# Index/Data Configuration Register File

This block holds a 256-entry file of byte registers that a host reaches through two byte-wide I/O ports. The low port (offset 0) selects a register by loading an index. The high port (offset 1) reads or writes the register that the index selects. The index is kept in entry 0 of the file itself. For that reason a data read with index 0 returns zero, and entry 0 cannot be written through the data port. Many indices are read-only, and data-port writes to them are dropped. A few entries come out of reset with fixed values: an identification byte, a function-select byte and base addresses for the attached floppy, parallel and serial devices. The parallel and both serial base registers are also driven out as ports so that address decoders further on can use them.

The port pair only responds when it is enabled. A bridge configuration byte write bus sets the enable. A write to configuration address `ENABLE_OFFSET` loads the enable from the bits of `ENABLE_MASK`. While the pair is disabled, reads answer 0xFF and writes do nothing, and the register contents are kept.

A small access sequencer handles each port request. In `S_IDLE` it accepts one request and moves to one of five states:
- `S_SET_INDEX` for an index write.
- `S_PUT_DATA` for a data write.
- `S_GET_INDEX` for an index read.
- `S_GET_DATA` for a data read.
- `S_GET_OFF` for a read while disabled.

Each of these five states lasts one cycle and then returns to `S_IDLE`. A write while disabled stays in `S_IDLE`. The commit states write the file at their closing edge. The read states drive the read data and the valid strobe.

Top module: `sio_cfg_regfile`

## Requirements
- R1: After reset the index is 0, the port pair is disabled, `io_rvalid` is 0, and the exported bases are 0xDE (parallel, entry 0xE6), 0xFE (serial 1, entry 0xE7) and 0xBE (serial 2, entry 0xE8).
- R2: A write with `io_addr`=0 loads the index. A later read with `io_addr`=0 returns the index. Read data appears with `io_rvalid` high during the single cycle after the edge that samples `io_rd`.
- R3: A read with `io_addr`=1 returns 0 whenever the index is 0.
- R4: Data writes (`io_addr`=1) take effect at indices 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC, and a data read then returns the written byte.
- R5: Data writes at every other index (0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB, 0xFD–0xFF) leave the entry unchanged. A write at index 0 also leaves the index unchanged.
- R6: Reset values are 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. Every other entry resets to 0.
- R7: A bridge write to address 0x85 sets the enable to the OR of its data bits under mask 0x02 (bit 1). Writes to other bridge addresses leave the enable unchanged.
- R8: While disabled, reads of either port return 0xFF and writes have no effect. Contents survive a disable/enable cycle.
- R9: `par_base`, `ser1_base` and `ser2_base` follow entries 0xE6, 0xE7 and 0xE8 from the cycle after a data write commits.
- R10: If `io_wr` and `io_rd` are sampled high together, only the write is performed and no read response is produced.
- R11: A request sampled while the sequencer is not in `S_IDLE` is ignored, so accepted requests are at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Bridge configuration byte write strobe |
| cfg_addr | input | 8 | Bridge configuration byte address |
| cfg_wdata | input | 8 | Bridge configuration write data |
| io_rd | input | 1 | Port read request |
| io_wr | input | 1 | Port write request |
| io_addr | input | 1 | Port offset: 0 index, 1 data |
| io_wdata | input | 8 | Port write byte |
| io_rdata | output | 8 | Port read byte, valid with io_rvalid |
| io_rvalid | output | 1 | Read response strobe |
| par_base | output | 8 | Parallel port base register (entry 0xE6) |
| ser1_base | output | 8 | Serial 1 base register (entry 0xE7) |
| ser2_base | output | 8 | Serial 2 base register (entry 0xE8) |

## Verification
The bench builds the block with its default parameters. These are enable address 0x85, enable mask 0x02 and disabled read value 0xFF, so the full 256-entry index space is reachable. That includes the boundary between the read-only low range and the writable 0xE0, and the top entry 0xFF. With these values a sweep over every index can compare write-then-read results against an independent model of the writable set. The defaults also let the bench drive the enable on and off, check reads while disabled, and exercise the sequencer states on overlapping and simultaneous requests.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned IDX_W    = 8;
    localparam int unsigned NUM_REGS = 1 << IDX_W;

    localparam logic [IDX_W-1:0] IDX_PAR  = 8'hE6;
    localparam logic [IDX_W-1:0] IDX_SER1 = 8'hE7;
    localparam logic [IDX_W-1:0] IDX_SER2 = 8'hE8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SET_INDEX,
        S_PUT_DATA,
        S_GET_INDEX,
        S_GET_DATA,
        S_GET_OFF
    } acc_state_e;

    // Entries that accept data-port writes; all others are protected.
    function automatic logic entry_writable(input logic [IDX_W-1:0] i);
        return i inside {[8'hE0:8'hE3], [8'hE6:8'hE8], [8'hEE:8'hF2],
                         8'hF4, 8'hF6, 8'hF8, 8'hFC};
    endfunction

    function automatic logic [REG_W-1:0] entry_default(input logic [IDX_W-1:0] i);
        logic [REG_W-1:0] v;
        case (i)
            8'hE0:   v = 8'h3C;
            8'hE2:   v = 8'h03;
            8'hE3:   v = 8'hFC;
            IDX_PAR: v = 8'hDE;
            IDX_SER1: v = 8'hFE;
            IDX_SER2: v = 8'hBE;
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/sio_cfg_gate.sv
module sio_cfg_gate #(
    parameter logic [7:0] ENABLE_OFFSET = 8'h85,
    parameter logic [7:0] ENABLE_MASK   = 8'h02
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic       port_en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en <= 1'b0;
        end else if (cfg_wr && (cfg_addr == ENABLE_OFFSET)) begin
            port_en <= |(cfg_wdata & ENABLE_MASK);
        end
    end
endmodule

// File: rtl/sio_cfg_store.sv
module sio_cfg_store
    import sio_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_we,
    input  logic             dat_we,
    input  logic [REG_W-1:0] wdata,
    output logic [IDX_W-1:0] cur_idx,
    output logic [REG_W-1:0] sel_data,
    output logic [REG_W-1:0] par_base,
    output logic [REG_W-1:0] ser1_base,
    output logic [REG_W-1:0] ser2_base
);
    logic [REG_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem[i] <= entry_default(IDX_W'(i));
            end
        end else if (idx_we) begin
            mem[0] <= wdata;
        end else if (dat_we && entry_writable(cur_idx)) begin
            mem[cur_idx] <= wdata;
        end
    end

    // Entry 0 carries the index; reading it as data yields zero.
    assign cur_idx   = IDX_W'(mem[0]);
    assign sel_data  = (cur_idx == '0) ? '0 : mem[cur_idx];
    assign par_base  = mem[IDX_PAR];
    assign ser1_base = mem[IDX_SER1];
    assign ser2_base = mem[IDX_SER2];
endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
    import sio_cfg_pkg::*;
#(
    parameter logic [REG_W-1:0] OFF_READ_VALUE = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic             io_addr,
    input  logic [REG_W-1:0] io_wdata,
    input  logic             port_en,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [REG_W-1:0] sel_data,
    output logic             idx_we,
    output logic             dat_we,
    output logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] io_rdata,
    output logic             io_rvalid,
    output acc_state_e       state
);
    acc_state_e nxt;

    always_comb begin
        nxt = S_IDLE;
        unique case (state)
            S_IDLE: begin
                if (io_wr) begin
                    if (port_en) nxt = io_addr ? S_PUT_DATA : S_SET_INDEX;
                end else if (io_rd) begin
                    if (!port_en)     nxt = S_GET_OFF;
                    else if (io_addr) nxt = S_GET_DATA;
                    else              nxt = S_GET_INDEX;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            wdata <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE) wdata <= io_wdata;
        end
    end

    always_comb begin
        idx_we    = 1'b0;
        dat_we    = 1'b0;
        io_rvalid = 1'b0;
        io_rdata  = '0;
        unique case (state)
            S_SET_INDEX: idx_we = 1'b1;
            S_PUT_DATA:  dat_we = 1'b1;
            S_GET_INDEX: begin io_rvalid = 1'b1; io_rdata = REG_W'(cur_idx); end
            S_GET_DATA:  begin io_rvalid = 1'b1; io_rdata = sel_data; end
            S_GET_OFF:   begin io_rvalid = 1'b1; io_rdata = OFF_READ_VALUE; end
            default: ;
        endcase
    end
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0]       ENABLE_OFFSET  = 8'h85,
    parameter logic [7:0]       ENABLE_MASK    = 8'h02,
    parameter logic [REG_W-1:0] OFF_READ_VALUE = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic             io_addr,
    input  logic [REG_W-1:0] io_wdata,
    output logic [REG_W-1:0] io_rdata,
    output logic             io_rvalid,
    output logic [REG_W-1:0] par_base,
    output logic [REG_W-1:0] ser1_base,
    output logic [REG_W-1:0] ser2_base
);
    logic             port_en;
    logic             idx_we;
    logic             dat_we;
    logic [REG_W-1:0] wdata;
    logic [IDX_W-1:0] cur_idx;
    logic [REG_W-1:0] sel_data;
    acc_state_e       state;

    sio_cfg_gate #(
        .ENABLE_OFFSET(ENABLE_OFFSET),
        .ENABLE_MASK  (ENABLE_MASK)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .port_en  (port_en)
    );

    sio_cfg_ctrl #(
        .OFF_READ_VALUE(OFF_READ_VALUE)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .port_en  (port_en),
        .cur_idx  (cur_idx),
        .sel_data (sel_data),
        .idx_we   (idx_we),
        .dat_we   (dat_we),
        .wdata    (wdata),
        .io_rdata (io_rdata),
        .io_rvalid(io_rvalid),
        .state    (state)
    );

    sio_cfg_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_we   (idx_we),
        .dat_we   (dat_we),
        .wdata    (wdata),
        .cur_idx  (cur_idx),
        .sel_data (sel_data),
        .par_base (par_base),
        .ser1_base(ser1_base),
        .ser2_base(ser2_base)
    );
endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker
    import sio_cfg_pkg::*;
#(
    parameter logic [REG_W-1:0] OFF_READ_VALUE = 8'hFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_rd,
    input logic             io_wr,
    input logic             io_addr,
    input logic             port_en,
    input acc_state_e       state,
    input logic [IDX_W-1:0] cur_idx,
    input logic             io_rvalid,
    input logic [REG_W-1:0] io_rdata,
    input logic [REG_W-1:0] par_base,
    input logic [REG_W-1:0] ser1_base,
    input logic [REG_W-1:0] ser2_base
);
    assert_rvalid_from_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |-> ($past(io_rd) && !$past(io_wr)));

    assert_rvalid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |=> !io_rvalid);

    assert_index_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rvalid && $past(port_en) && !$past(io_addr)) |-> (io_rdata == REG_W'($past(cur_idx))));

    assert_zero_index_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rvalid && $past(port_en) && $past(io_addr) && ($past(cur_idx) == '0)) |-> (io_rdata == '0));

    assert_disabled_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rvalid && !$past(port_en)) |-> (io_rdata == OFF_READ_VALUE));

    assert_index_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != S_SET_INDEX) |-> $stable(cur_idx));

    assert_exports_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != S_PUT_DATA) |-> $stable({par_base, ser1_base, ser2_base}));
endmodule

bind sio_cfg_regfile sio_cfg_checker #(.OFF_READ_VALUE(OFF_READ_VALUE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .port_en  (port_en),
    .state    (state),
    .cur_idx  (cur_idx),
    .io_rvalid(io_rvalid),
    .io_rdata (io_rdata),
    .par_base (par_base),
    .ser1_base(ser1_base),
    .ser2_base(ser2_base)
);

// File: tb/sim_sio_cfg_regfile.sv
module sim_sio_cfg_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic       io_addr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       io_rvalid;
    logic [7:0] par_base, ser1_base, ser2_base;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    always #5 clk = ~clk;

    sio_cfg_regfile u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .par_base(par_base), .ser1_base(ser1_base), .ser2_base(ser2_base)
    );

    function automatic bit m_writable(input int i);
        if (i < 8'hE0) return 1'b0;
        return !(i inside {8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3, 8'hF5, 8'hF7,
                           [8'hF9:8'hFB], [8'hFD:8'hFF]});
    endfunction

    function automatic logic [7:0] m_reset(input int i);
        if (i == 8'hE0) return 8'h3C;
        if (i == 8'hE2) return 8'h03;
        if (i == 8'hE3) return 8'hFC;
        if (i == 8'hE6) return 8'hDE;
        if (i == 8'hE7) return 8'hFE;
        if (i == 8'hE8) return 8'hBE;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    task automatic port_write(input logic a, input logic [7:0] d);
        @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk); io_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic port_read(input logic a, output logic [7:0] d, output logic v, output logic v2);
        @(negedge clk); io_rd = 1'b1; io_addr = a;
        @(negedge clk); io_rd = 1'b0; v = io_rvalid; d = io_rdata;
        @(negedge clk); v2 = io_rvalid;
    endtask

    task automatic bridge_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    function automatic logic [7:0] rd_val(input logic a);
        return 8'h00;
    endfunction

    task automatic t_reset();
        logic [7:0] d; logic v, v2;
        chk("R1 rvalid", {7'b0, io_rvalid}, 8'h00);
        chk("R1 par_base", par_base, 8'hDE);
        chk("R1 ser1_base", ser1_base, 8'hFE);
        chk("R1 ser2_base", ser2_base, 8'hBE);
        port_read(1'b0, d, v, v2);
        chk("R1 disabled at reset", d, 8'hFF);
    endtask

    task automatic t_enable();
        logic [7:0] d; logic v, v2;
        bridge_write(8'h84, 8'h02);
        port_read(1'b0, d, v, v2);
        chk("R7 other address no enable", d, 8'hFF);
        bridge_write(8'h85, 8'hFD);
        port_read(1'b0, d, v, v2);
        chk("R7 mask bit clear", d, 8'hFF);
        bridge_write(8'h85, 8'h02);
        port_read(1'b0, d, v, v2);
        chk("R7 enabled index read", d, 8'h00);
        chk("R7 rvalid", {7'b0, v}, 8'h01);
    endtask

    task automatic t_defaults();
        logic [7:0] d; logic v, v2;
        for (int i = 8'hE0; i < 256; i++) begin
            port_write(1'b0, 8'(i));
            port_read(1'b1, d, v, v2);
            chk($sformatf("R6 default idx %02h", i), d, m_reset(i));
        end
    endtask

    task automatic t_index();
        logic [7:0] d; logic v, v2;
        port_write(1'b0, 8'h5A);
        port_read(1'b0, d, v, v2);
        chk("R2 index readback", d, 8'h5A);
        chk("R2 rvalid high", {7'b0, v}, 8'h01);
        chk("R2 rvalid one cycle", {7'b0, v2}, 8'h00);
    endtask

    task automatic t_zero_index();
        logic [7:0] d; logic v, v2;
        port_write(1'b0, 8'h00);
        port_read(1'b1, d, v, v2);
        chk("R3 data at index 0", d, 8'h00);
        port_write(1'b1, 8'h77);
        port_read(1'b0, d, v, v2);
        chk("R5 index unchanged by data write at 0", d, 8'h00);
        port_read(1'b1, d, v, v2);
        chk("R3 data at index 0 after write", d, 8'h00);
    endtask

    task automatic t_back_to_back();
        logic [7:0] d; logic v, v2;
        @(negedge clk); io_wr = 1'b1; io_addr = 1'b0; io_wdata = 8'hF6;
        @(negedge clk); io_addr = 1'b1; io_wdata = 8'h99;
        @(negedge clk); io_wr = 1'b0;
        @(negedge clk);
        port_read(1'b0, d, v, v2);
        chk("R11 first request taken", d, 8'hF6);
        port_read(1'b1, d, v, v2);
        chk("R11 overlapping request dropped", d, 8'h00);
    endtask

    task automatic t_both();
        logic [7:0] d; logic v, v2;
        @(negedge clk); io_wr = 1'b1; io_rd = 1'b1; io_addr = 1'b0; io_wdata = 8'h44;
        @(negedge clk); io_wr = 1'b0; io_rd = 1'b0; v = io_rvalid;
        @(negedge clk);
        chk("R10 no read response", {7'b0, v}, 8'h00);
        port_read(1'b0, d, v, v2);
        chk("R10 write performed", d, 8'h44);
    endtask

    task automatic t_sweep();
        logic [7:0] d; logic v, v2;
        logic [7:0] p, e;
        for (int i = 0; i < 256; i++) begin
            p = 8'(i) ^ 8'hA5;
            port_write(1'b0, 8'(i));
            port_write(1'b1, p);
            port_read(1'b1, d, v, v2);
            if (i == 0) e = 8'h00;
            else e = m_writable(i) ? p : m_reset(i);
            if (m_writable(i)) chk($sformatf("R4 writable idx %02h", i), d, e);
            else chk($sformatf("R5 protected idx %02h", i), d, e);
        end
    endtask

    task automatic t_exports();
        chk("R9 par after sweep", par_base, 8'hE6 ^ 8'hA5);
        chk("R9 ser1 after sweep", ser1_base, 8'hE7 ^ 8'hA5);
        chk("R9 ser2 after sweep", ser2_base, 8'hE8 ^ 8'hA5);
        port_write(1'b0, 8'hE7);
        port_write(1'b1, 8'h12);
        chk("R9 ser1 follows write", ser1_base, 8'h12);
        port_write(1'b0, 8'hE8);
        port_write(1'b1, 8'h34);
        chk("R9 ser2 follows write", ser2_base, 8'h34);
        port_write(1'b0, 8'hE6);
        port_write(1'b1, 8'h56);
        chk("R9 par follows write", par_base, 8'h56);
    endtask

    task automatic t_disabled();
        logic [7:0] d; logic v, v2;
        port_write(1'b0, 8'hF0);
        port_write(1'b1, 8'h11);
        bridge_write(8'h85, 8'h00);
        port_write(1'b0, 8'h22);
        port_write(1'b1, 8'h33);
        port_read(1'b0, d, v, v2);
        chk("R8 disabled index read", d, 8'hFF);
        port_read(1'b1, d, v, v2);
        chk("R8 disabled data read", d, 8'hFF);
        bridge_write(8'h85, 8'h02);
        port_read(1'b0, d, v, v2);
        chk("R8 index kept", d, 8'hF0);
        port_read(1'b1, d, v, v2);
        chk("R8 data kept", d, 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_defaults();
        t_index();
        t_zero_index();
        t_back_to_back();
        t_both();
        t_sweep();
        t_exports();
        t_disabled();
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
        $finish;
    end
endmodule